// File: doc/BRIEF.md
# Scrambled Differential Convolutional Encoder

This block is the transmit half of a rate-1/2, constraint-length-7 forward error correction link. Every time the bit strobe is high, it accepts one data bit. The bit can pass through a self-synchronising scrambler and then a differential encoder, each with its own enable. The result is shifted into the convolutional encoder, which produces two coded symbols in parallel.

The scrambler has two variants. They share one feedback polynomial, and they differ only in an anti-lockup rule that breaks up long constant runs. A serial symbol output is also provided for binary phase modulation. The strobe is normally driven every other clock cycle, and the serial output then carries the first symbol in the strobe cycle's half and the second symbol in the following half.

Top module: `scr_diff_conv_enc`

## Requirements
- R1: While `rst_n` is low, the encoder memory, scrambler state, run counter and differential state are all zero, and `g1_sym`, `g2_sym` and `ser_sym` read 0.
- R2: Let `w[6:0]` be the encoder window, with `w[6]` the bit entering now and `w[0]` the bit that entered six strobes earlier. After each strobe, `g1_sym` is the XOR of `w` masked with 171 octal (binary 1111001).
- R3: After each strobe, `g2_sym` is the XOR of the same window masked with 133 octal (binary 1011011).
- R4: The symbols change only on a clock edge where `bit_en` is high. On all other edges they keep their value.
- R5: With `scr_en` high, the scrambled bit is the input bit XOR the scrambler outputs from 3 and 20 strobes earlier. The scrambler history records its own outputs on every strobe, whether or not scrambling is enabled.
- R6: A run counter tracks how many consecutive input bits match the previous input bit. Reset counts as a previous bit of 0. When the counter has reached 32 and `iess_sel` is high, the next scrambled bit is inverted and the counter restarts at 0.
- R7: With `iess_sel` low, no bit is ever inverted. For example, an all-zero input that is scrambled and not differentially encoded gives all-zero symbols.
- R8: The differential bit is the stage input XOR the previous differential bit. This state updates on every strobe, and its output is used only when `diff_en` is high.
- R9: The stages run in a fixed order: scrambler, then differential encoder, then convolutional encoder.
- R10: On the edge where `bit_en` is high, `ser_sym` shows `g1_sym`. On the following edge where `bit_en` is low, it switches to `g2_sym`.
- R11: With `scr_en` and `diff_en` both low, the data bit enters the encoder unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit strobe; accepts `din` |
| din | input | 1 | Data bit |
| scr_en | input | 1 | Scrambler enable |
| iess_sel | input | 1 | 1: anti-lockup scrambler variant, 0: plain variant |
| diff_en | input | 1 | Differential encoder enable |
| g1_sym | output | 1 | Symbol from generator 171 octal |
| g2_sym | output | 1 | Symbol from generator 133 octal |
| ser_sym | output | 1 | Serialised symbol, G1 then G2 |

## Verification
The bench builds the block with its default parameters: generators 171 and 133 octal, scrambler taps at 3 and 20, and an anti-lockup run of 32. With a run length of 32, long constant runs trigger the inversion within a few dozen bits. This lets directed all-zero runs show the first inverted bit at strobe 33 in one variant and no inversion in the other. Random data under each of the four enable combinations then exercises the stage ordering and the serial phase against a bench model.

// File: rtl/scr_diff_conv_enc.sv
module scr_diff_conv_enc #(
  parameter int          K        = 7,
  parameter logic [K-1:0] G1_POLY = 7'o171,
  parameter logic [K-1:0] G2_POLY = 7'o133,
  parameter int          TAP_A    = 3,
  parameter int          TAP_B    = 20,
  parameter int          LOCK_RUN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic din,
  input  logic scr_en,
  input  logic iess_sel,
  input  logic diff_en,
  output logic g1_sym,
  output logic g2_sym,
  output logic ser_sym
);
  localparam int MEM   = K - 1;
  localparam int RUN_W = $clog2(LOCK_RUN + 1);

  logic [TAP_B-1:0] scr_q;
  logic [RUN_W-1:0] run_q;
  logic [MEM-1:0]   sr_q;
  logic             prev_in_q, diff_q, half_q;

  wire lock_hit  = (run_q == RUN_W'(LOCK_RUN));
  wire flip      = iess_sel && lock_hit;
  wire scr_bit   = din ^ scr_q[TAP_A-1] ^ scr_q[TAP_B-1] ^ flip;
  wire after_scr = scr_en ? scr_bit : din;
  wire diff_bit  = after_scr ^ diff_q;
  wire enc_bit   = diff_en ? diff_bit : after_scr;
  wire [K-1:0] win = {enc_bit, sr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q     <= '0;
      run_q     <= '0;
      sr_q      <= '0;
      prev_in_q <= 1'b0;
      diff_q    <= 1'b0;
      half_q    <= 1'b0;
      g1_sym    <= 1'b0;
      g2_sym    <= 1'b0;
    end else if (bit_en) begin
      scr_q     <= {scr_q[TAP_B-2:0], scr_bit};
      prev_in_q <= din;
      if (flip)                 run_q <= '0;
      else if (din != prev_in_q) run_q <= RUN_W'(1);
      else if (!lock_hit)        run_q <= run_q + RUN_W'(1);
      diff_q    <= diff_bit;
      sr_q      <= {enc_bit, sr_q[MEM-1:1]};
      g1_sym    <= ^(win & G1_POLY);
      g2_sym    <= ^(win & G2_POLY);
      half_q    <= 1'b0;
    end else begin
      half_q    <= 1'b1;
    end
  end

  assign ser_sym = half_q ? g2_sym : g1_sym;

  AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(g1_sym) && $stable(g2_sym)));                       // R4
  AST_SER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (ser_sym == g1_sym));                                         // R10
  AST_SER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> (ser_sym == g2_sym));                                        // R10
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !scr_en && !diff_en) |=> (sr_q[MEM-1] == $past(din)));        // R11
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(LOCK_RUN));                                              // R6
  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && iess_sel && lock_hit) |=> (run_q == '0));                     // R6
endmodule

// File: tb/scr_diff_conv_enc_bench.sv
module scr_diff_conv_enc_bench;
  logic clk = 0, rst_n = 0, bit_en = 0, din = 0;
  logic scr_en = 0, iess_sel = 0, diff_en = 0;
  logic g1_sym, g2_sym, ser_sym;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scr_diff_conv_enc u_scr_diff_conv_enc (.*);

  logic [19:0] m_scr;
  logic [5:0]  m_sr;
  logic        m_prev, m_diff, e_g1, e_g2;
  int          m_run;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_scr = '0; m_sr = '0; m_prev = 0; m_diff = 0; m_run = 0;
  endtask

  task automatic model_step(input logic b);
    logic flip, y, x, d, e;
    logic [6:0] w;
    flip = iess_sel && (m_run == 32);
    y = b ^ m_scr[2] ^ m_scr[19] ^ flip;
    x = scr_en ? y : b;
    d = x ^ m_diff;
    e = diff_en ? d : x;
    w = {e, m_sr};
    e_g1 = ^(w & 7'b1111001);
    e_g2 = ^(w & 7'b1011011);
    m_scr = {m_scr[18:0], y};
    if (flip) m_run = 0;
    else if (b != m_prev) m_run = 1;
    else if (m_run < 32) m_run++;
    m_prev = b;
    m_diff = d;
    m_sr = {e, m_sr[5:1]};
  endtask

  task automatic send_bit(input logic b, input string req);
    @(negedge clk);
    din = b; bit_en = 1;
    model_step(b);
    @(negedge clk);
    bit_en = 0;
    chk({req, " g1"}, g1_sym, e_g1);
    chk({req, " g2"}, g2_sym, e_g2);
    chk("R10 ser first", ser_sym, e_g1);
    @(negedge clk);
    chk("R10 ser second", ser_sym, e_g2);
    chk("R4 g1 held", g1_sym, e_g1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bit_en = 0;
    @(negedge clk);
    chk("R1 g1", g1_sym, 1'b0);
    chk("R1 g2", g2_sym, 1'b0);
    chk("R1 ser", ser_sym, 1'b0);
    model_reset();
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0117));
    model_reset();
    do_reset();

    // R2 R3: impulse response through bypassed stages (R11)
    send_bit(1, "R2 R3 R11 impulse");
    for (int i = 0; i < 7; i++) send_bit(0, "R2 R3 R11 impulse tail");

    // R7: plain variant, long zero run stays all-zero
    do_reset();
    scr_en = 1; iess_sel = 0; diff_en = 0;
    for (int i = 1; i <= 70; i++) begin
      send_bit(0, "R7 model");
      chk("R7 zero g1", g1_sym, 1'b0);
    end

    // R6: anti-lockup variant, first inversion at strobe 33
    do_reset();
    scr_en = 1; iess_sel = 1; diff_en = 0;
    for (int i = 1; i <= 40; i++) begin
      send_bit(0, "R6 model");
      chk("R6 direct g1", g1_sym, (i == 33) ? 1'b1 : (i < 33 ? 1'b0 : e_g1));
    end

    // R8: differential alone on constant ones alternates the encoder input
    do_reset();
    scr_en = 0; diff_en = 1;
    for (int i = 0; i < 12; i++) send_bit(1, "R8 diff");

    // R5 R8 R9 R11: random data under all enable combinations
    for (int mode = 0; mode < 8; mode++) begin
      do_reset();
      scr_en = mode[0]; diff_en = mode[1]; iess_sel = mode[2];
      for (int i = 0; i < 60; i++) send_bit(logic'($urandom_range(0, 1)), "R5 R9 random");
      for (int i = 0; i < 40; i++) send_bit(1, "R6 R5 ones run");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule